// File: doc/BRIEF.md
# Pulse Output Emergency Shutdown Controller

This block guards a set of complementary PWM output pairs that drive high-current pins. It puts those pins into high impedance when an external active-low shutdown request is qualified, or when both outputs of any pair are low at once. That second case is a short condition, because both switches of a half-bridge are then on. Each cause latches a sticky flag of its own, and the pins stay in high impedance while either flag is set.

Software selects how the request input is qualified. One setting accepts a single falling edge. The other three settings accept a low level only after sixteen consecutive low samples, taken at the clock divided by 8, 16 or 128. The request input first passes through a two-stage synchronizer. An interrupt line reports the short flag when its enable bit is set.

The flags are cleared over a small register bus. A flag clears only when a 0 is written to it after software has read it as 1.

Top module: `pose_shutdown_ctl`

## Requirements
- R1: After reset both flags are 0, the mode is 00, the interrupt enable is 0, `pins_hiz` and `short_irq` are 0, and both registers read 0.
- R2: In mode 00 a falling edge on `shdn_req_n` sets the request flag. The flag is visible after the third rising clock edge that follows the input change, and not after the second. A level held low does not set the flag again once it has been cleared.
- R3: In mode 01 the request is accepted only after 16 consecutive low samples taken once every 8 clocks. It is never accepted within 15*8 cycles of the input falling, and it is always accepted within 17*8+4 cycles. A low pulse shorter than that is ignored.
- R4: Modes 10 and 11 behave like mode 01, but they sample once every 16 clocks and once every 128 clocks.
- R5: Any high sample restarts the count of low samples. A write that changes the mode field also restarts the count.
- R6: If `pwm_hi[i]` and `pwm_lo[i]` are both 0 for any pair i, the short flag is set at the next rising edge. Both outputs of a pair being high is not a short.
- R7: `pins_hiz` is 1 whenever the request flag or the short flag is 1, and 0 otherwise.
- R8: Each flag clears only when a write puts 0 in its bit 15 after a read has returned that bit as 1. Writing 1 leaves the flag set. A write of 0 with no such read before it leaves the flag set. Every write to the register cancels an earlier read.
- R9: `short_irq` is 1 exactly while the short flag is 1 and the interrupt enable bit is 1.
- R10: The control register is at address 0. Bit 15 is the request flag and bits 1:0 are the mode. The status register is at address 1. Bit 15 is the short flag and bit 8 is the interrupt enable. All other bits of both registers read 0, including the reserved bits 14 to 10 of the status register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn_req_n | input | 1 | External active-low shutdown request, asynchronous |
| pwm_hi | input | 3 | High-side output of each complementary pair |
| pwm_lo | input | 3 | Low-side output of each complementary pair |
| bus_sel | input | 1 | Register bus select |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_addr | input | 1 | Register address, 0 = control, 1 = status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address while selected |
| pins_hiz | output | 1 | Force high-current pins to high impedance |
| short_irq | output | 1 | Short-condition interrupt |

## Verification
A short on a pair shows on `pins_hiz` after one edge. An edge-mode request needs three edges: two synchronizer stages and the flag register. The bench checks both sides of the edge-mode boundary, with no flag after two edges and the flag after three. The prescaler phase is unknown to the bench, so a filtered request can only be placed in a window. The bench therefore checks that nothing has happened after 15 sample periods and that the flag is set after 17 periods plus a few cycles. Inputs change on the falling clock edge, outputs are sampled on the falling clock edge, and read data is taken while the read strobe is still asserted.

// File: rtl/pose_pkg.sv
package pose_pkg;
    localparam int DATA_W   = 16;
    localparam int FLAG_BIT = 15;
    localparam int IE_BIT   = 8;
    localparam int MODE_W   = 2;

    typedef enum logic [MODE_W-1:0] {
        QM_EDGE  = 2'b00,
        QM_DIV_A = 2'b01,
        QM_DIV_B = 2'b10,
        QM_DIV_C = 2'b11
    } qual_mode_e;
endpackage

// File: rtl/pose_req_qualifier.sv
module pose_req_qualifier
    import pose_pkg::*;
#(
    parameter int FILT_LEN = 16,
    parameter int DIV_A    = 8,
    parameter int DIV_B    = 16,
    parameter int DIV_C    = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_n,
    input  qual_mode_e mode,
    input  logic       mode_chg,
    output logic       accept
);
    localparam int PRE_W = $clog2(DIV_C);
    localparam int CNT_W = $clog2(FILT_LEN);

    typedef struct packed {
        logic             s1;
        logic             s2;
        logic             s3;
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
    } qual_st_t;

    qual_st_t         st_d, st_q;
    logic [PRE_W-1:0] mask;
    logic             tick;

    always_comb begin
        st_d     = st_q;
        st_d.s1  = req_n;
        st_d.s2  = st_q.s1;
        st_d.s3  = st_q.s2;
        st_d.pre = st_q.pre + 1'b1;

        case (mode)
            QM_DIV_A: mask = PRE_W'(DIV_A - 1);
            QM_DIV_B: mask = PRE_W'(DIV_B - 1);
            QM_DIV_C: mask = PRE_W'(DIV_C - 1);
            default:  mask = '0;
        endcase
        tick = (mode != QM_EDGE) && ((st_q.pre & mask) == mask);

        accept = (mode == QM_EDGE) && st_q.s3 && !st_q.s2;

        if (mode_chg) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (st_q.s2) begin
                st_d.cnt = '0;
            end else if (st_q.cnt == CNT_W'(FILT_LEN - 1)) begin
                accept = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.s1  <= 1'b1;
            st_q.s2  <= 1'b1;
            st_q.s3  <= 1'b1;
            st_q.pre <= '0;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pose_pair_short.sv
module pose_pair_short #(
    parameter int NPAIR = 3
) (
    input  logic [NPAIR-1:0] hi,
    input  logic [NPAIR-1:0] lo,
    output logic             short_any
);
    logic [NPAIR-1:0] both_low;

    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        assign both_low[g] = ~hi[g] & ~lo[g];
    end

    assign short_any = |both_low;
endmodule

// File: rtl/pose_sticky_flag.sv
module pose_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wbit_i,
    output logic flag_o
);
    typedef struct packed {
        logic flag;
        logic armed;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_i && st_q.flag) begin
            st_d.armed = 1'b1;
        end
        if (wr_i) begin
            if (st_q.armed && !wbit_i) begin
                st_d.flag = 1'b0;
            end
            st_d.armed = 1'b0;
        end
        if (set_i) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/pose_shutdown_ctl.sv
module pose_shutdown_ctl
    import pose_pkg::*;
#(
    parameter int NPAIR    = 3,
    parameter int FILT_LEN = 16,
    parameter int DIV_A    = 8,
    parameter int DIV_B    = 16,
    parameter int DIV_C    = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shdn_req_n,
    input  logic [NPAIR-1:0]  pwm_hi,
    input  logic [NPAIR-1:0]  pwm_lo,
    input  logic              bus_sel,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pins_hiz,
    output logic              short_irq
);
    typedef struct packed {
        qual_mode_e mode;
        logic       ie;
    } ctl_st_t;

    ctl_st_t ctl_d, ctl_q;
    logic    ctl_wr, sts_wr, ctl_rd, sts_rd;
    logic    mode_chg, accept, short_now;
    logic    req_flag, short_flag;

    always_comb begin
        ctl_wr   = bus_sel && bus_wr && !bus_addr;
        sts_wr   = bus_sel && bus_wr &&  bus_addr;
        ctl_rd   = bus_sel && bus_rd && !bus_addr;
        sts_rd   = bus_sel && bus_rd &&  bus_addr;
        ctl_d    = ctl_q;
        mode_chg = ctl_wr && (bus_wdata[MODE_W-1:0] != ctl_q.mode);
        if (ctl_wr) begin
            ctl_d.mode = qual_mode_e'(bus_wdata[MODE_W-1:0]);
        end
        if (sts_wr) begin
            ctl_d.ie = bus_wdata[IE_BIT];
        end

        bus_rdata = '0;
        if (bus_sel) begin
            if (!bus_addr) begin
                bus_rdata[FLAG_BIT]     = req_flag;
                bus_rdata[MODE_W-1:0]   = ctl_q.mode;
            end else begin
                bus_rdata[FLAG_BIT]     = short_flag;
                bus_rdata[IE_BIT]       = ctl_q.ie;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{mode: QM_EDGE, ie: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    pose_req_qualifier #(
        .FILT_LEN(FILT_LEN),
        .DIV_A   (DIV_A),
        .DIV_B   (DIV_B),
        .DIV_C   (DIV_C)
    ) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_n   (shdn_req_n),
        .mode    (ctl_q.mode),
        .mode_chg(mode_chg),
        .accept  (accept)
    );

    pose_pair_short #(.NPAIR(NPAIR)) u_short (
        .hi       (pwm_hi),
        .lo       (pwm_lo),
        .short_any(short_now)
    );

    pose_sticky_flag u_req_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (accept),
        .rd_i  (ctl_rd),
        .wr_i  (ctl_wr),
        .wbit_i(bus_wdata[FLAG_BIT]),
        .flag_o(req_flag)
    );

    pose_sticky_flag u_short_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (short_now),
        .rd_i  (sts_rd),
        .wr_i  (sts_wr),
        .wbit_i(bus_wdata[FLAG_BIT]),
        .flag_o(short_flag)
    );

    assign pins_hiz  = req_flag || short_flag;
    assign short_irq = short_flag && ctl_q.ie;
endmodule

// File: rtl/pose_shutdown_chk.sv
module pose_shutdown_chk #(
    parameter int NPAIR = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPAIR-1:0] pwm_hi,
    input logic [NPAIR-1:0] pwm_lo,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic             bus_addr,
    input logic [15:0]      bus_wdata,
    input logic [15:0]      bus_rdata,
    input logic             pins_hiz,
    input logic             short_irq,
    input logic             req_flag,
    input logic             short_flag
);
    logic pair_low;
    assign pair_low = |(~pwm_hi & ~pwm_lo);

    // R6 / R7: a short on any pair forces the flag and the pins on the next edge
    p_short_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pair_low |=> (short_flag && pins_hiz));

    // R9: interrupt never without the short flag
    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        short_irq |-> short_flag);

    // R8: writing 1 to the short flag leaves it set
    p_wr1_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr && bus_wdata[15] && short_flag) |=> short_flag);

    // R8: the request flag falls only through a control write
    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_flag && !(bus_sel && bus_wr && !bus_addr)) |=> req_flag);

    // R10: reserved status bits read zero
    p_rsv_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_addr) |-> (bus_rdata[14:10] == 5'd0));
endmodule

bind pose_shutdown_ctl pose_shutdown_chk #(.NPAIR(NPAIR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwm_hi    (pwm_hi),
    .pwm_lo    (pwm_lo),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pins_hiz  (pins_hiz),
    .short_irq (short_irq),
    .req_flag  (req_flag),
    .short_flag(short_flag)
);

// File: tb/tb_pose_shutdown_ctl.sv
`timescale 1ns/1ps
module tb_pose_shutdown_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        shdn_req_n = 1'b1;
    logic [2:0]  pwm_hi = 3'b111;
    logic [2:0]  pwm_lo = 3'b000;
    logic        bus_sel = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_addr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        pins_hiz;
    logic        short_irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [1:0] cur_mode = 2'b00;
    logic       cur_ie = 1'b0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    pose_shutdown_ctl dut (
        .clk(clk), .rst_n(rst_n), .shdn_req_n(shdn_req_n),
        .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
        .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pins_hiz(pins_hiz), .short_irq(short_irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bwrite(input logic a, input logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step(1);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bread(input logic a, output logic [15:0] d);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        step(1);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    function automatic logic [15:0] wr_val(input logic a);
        return a ? {7'd0, cur_ie, 8'd0} : {14'd0, cur_mode};
    endfunction

    task automatic clear_flag(input logic a);
        logic [15:0] d;
        bread(a, d);
        bwrite(a, wr_val(a));
    endtask

    task automatic set_mode(input logic [1:0] m);
        cur_mode = m;
        bwrite(1'b0, {14'd0, m});
    endtask

    task automatic t_reset_state;
        logic [15:0] d;
        chk(pins_hiz == 1'b0, "R1 pins_hiz", pins_hiz, 0);
        chk(short_irq == 1'b0, "R1 short_irq", short_irq, 0);
        bread(1'b0, d); chk(d == 16'h0000, "R1 ctrl reg", d, 16'h0000);
        bread(1'b1, d); chk(d == 16'h0000, "R1 status reg", d, 16'h0000);
    endtask

    task automatic t_edge_mode;
        logic [15:0] d;
        shdn_req_n = 1'b0;
        step(2);
        chk(pins_hiz == 1'b0, "R2 not yet after two edges", pins_hiz, 0);
        step(1);
        chk(pins_hiz == 1'b1, "R2/R7 hiz after three edges", pins_hiz, 1);
        bread(1'b0, d); chk(d[15] == 1'b1, "R2 request flag", d[15], 1);
        bwrite(1'b0, wr_val(1'b0));
        step(6);
        chk(pins_hiz == 1'b0, "R2 held low does not re-set", pins_hiz, 0);
        shdn_req_n = 1'b1;
        step(4);
    endtask

    task automatic t_clear_rules;
        logic [15:0] d;
        shdn_req_n = 1'b0; step(4); shdn_req_n = 1'b1; step(4);
        bwrite(1'b0, wr_val(1'b0));
        step(1);
        chk(pins_hiz == 1'b1, "R8 write 0 without read keeps flag", pins_hiz, 1);
        bread(1'b0, d);
        bwrite(1'b0, wr_val(1'b0) | 16'h8000);
        bread(1'b0, d);
        chk(d[15] == 1'b1, "R8 write 1 keeps flag", d[15], 1);
        bwrite(1'b0, wr_val(1'b0));
        step(1);
        chk(pins_hiz == 1'b0, "R8/R7 read-1 then write-0 clears", pins_hiz, 0);
        bread(1'b0, d); chk(d[15] == 1'b0, "R8 flag reads 0", d[15], 0);
    endtask

    task automatic t_short;
        logic [15:0] d;
        pwm_hi = 3'b111; pwm_lo = 3'b111;
        step(2);
        chk(pins_hiz == 1'b0, "R6 both high is not a short", pins_hiz, 0);
        pwm_hi = 3'b101; pwm_lo = 3'b000;
        step(1);
        pwm_hi = 3'b111;
        chk(pins_hiz == 1'b1, "R6 pair 1 both low", pins_hiz, 1);
        chk(short_irq == 1'b0, "R9 no irq with enable off", short_irq, 0);
        cur_ie = 1'b1;
        bwrite(1'b1, wr_val(1'b1) | 16'h8000);
        chk(short_irq == 1'b1, "R9 irq with enable on", short_irq, 1);
        clear_flag(1'b1);
        chk(short_irq == 1'b0, "R9 irq drops with flag", short_irq, 0);
        chk(pins_hiz == 1'b0, "R7 pins released", pins_hiz, 0);
        pwm_hi = 3'b011;
        step(1);
        pwm_hi = 3'b111;
        bread(1'b1, d);
        chk(d[15] == 1'b1, "R6 pair 2 both low", d[15], 1);
        bwrite(1'b1, wr_val(1'b1));
        cur_ie = 1'b0;
        bwrite(1'b1, wr_val(1'b1));
        chk(pins_hiz == 1'b0, "R8 short cleared", pins_hiz, 0);
    endtask

    task automatic t_filter(input logic [1:0] m, input int div, input string req);
        set_mode(m);
        shdn_req_n = 1'b0; step(3 * div); shdn_req_n = 1'b1; step(2 * div);
        chk(pins_hiz == 1'b0, {req, " short pulse ignored"}, pins_hiz, 0);
        shdn_req_n = 1'b0;
        step(15 * div);
        chk(pins_hiz == 1'b0, {req, " not before 15 periods"}, pins_hiz, 0);
        step(2 * div + 4);
        chk(pins_hiz == 1'b1, {req, " accepted by 17 periods"}, pins_hiz, 1);
        shdn_req_n = 1'b1; step(4);
        clear_flag(1'b0);
        set_mode(2'b00);
    endtask

    task automatic t_glitch;
        set_mode(2'b01);
        shdn_req_n = 1'b0; step(10 * 8);
        shdn_req_n = 1'b1; step(2 * 8);
        shdn_req_n = 1'b0; step(15 * 8);
        chk(pins_hiz == 1'b0, "R5 high sample restarts count", pins_hiz, 0);
        step(2 * 8 + 4);
        chk(pins_hiz == 1'b1, "R5 accepted after restart", pins_hiz, 1);
        shdn_req_n = 1'b1; step(4);
        clear_flag(1'b0);
        set_mode(2'b00);
    endtask

    task automatic t_mode_change;
        set_mode(2'b01);
        shdn_req_n = 1'b0; step(12 * 8);
        set_mode(2'b10);
        step(15 * 16);
        chk(pins_hiz == 1'b0, "R5 mode change restarts count", pins_hiz, 0);
        step(2 * 16 + 4);
        chk(pins_hiz == 1'b1, "R5 accepted in new mode", pins_hiz, 1);
        shdn_req_n = 1'b1; step(4);
        clear_flag(1'b0);
        set_mode(2'b00);
    endtask

    task automatic t_reg_layout;
        logic [15:0] d;
        bwrite(1'b1, 16'hFFFF);
        bread(1'b1, d); chk(d == 16'h0100, "R10 status layout", d, 16'h0100);
        bwrite(1'b0, 16'h7FFF);
        bread(1'b0, d); chk(d == 16'h0003, "R10 control layout", d, 16'h0003);
        bwrite(1'b1, 16'h0000);
        bwrite(1'b0, 16'h0000);
        cur_ie = 1'b0; cur_mode = 2'b00;
        chk(pins_hiz == 1'b0, "R10 no side effect on pins", pins_hiz, 0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        t_reset_state();
        t_edge_mode();
        t_clear_rules();
        t_short();
        t_filter(2'b01, 8,   "R3 div8");
        t_filter(2'b10, 16,  "R4 div16");
        t_filter(2'b11, 128, "R4 div128");
        t_glitch();
        t_mode_change();
        t_reg_layout();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule